// File: doc/BRIEF.md
# Dual-Compare 8-Bit Timer Channel

An 8-bit up-counter that advances on a count-enable strobe and is compared every enabled cycle against two programmable compare values. A compare hit or a counter wrap raises a sticky event flag. Each flag can drive an interrupt request line through its own enable input. Software can lower a flag only in two ways: it reads the flag as 1 and then writes 0 to it, or an external transfer engine acknowledges the interrupt with its keep-flag qualifier low.

Each compare hit can also act on one waveform output pin. The pin can hold, go low, go high or toggle, and the action is chosen per compare. A hit on compare A can also emit a one-cycle converter start pulse. A small register bus gives access to the counter, both compare values and a combined control/status register. A build parameter selects a variant channel with no converter trigger.

Top module: `tmr8_channel`

## Requirements
- R1: After synchronous reset the counter reads 0x00, both compare registers read 0xFF, the control/status register reads 0x00 (0x10 in the variant without converter trigger), and wave_out, adc_start and all irq outputs are 0.
- R2: Bus address 0 is the counter, 1 is compare A, 2 is compare B, 3 is control/status. The counter goes up by 1 on each clock with cnt_en high, holds when cnt_en is low, and a bus write to address 0 loads it.
- R3: The overflow flag (status bit 5) sets when an enabled count takes the counter from 0xFF to 0x00.
- R4: The match-A flag (bit 6) sets when cnt_en is high while the counter equals compare A. The match-B flag (bit 7) sets in the same way for compare B.
- R5: A flag clears only when a write of 0 to its bit follows a read of the status register that returned it as 1, with no status write in between. Writing 1 has no effect, and writing 0 without that read has no effect.
- R6: When a flag's set condition and its clear fall in the same cycle, the flag ends up set.
- R7: dack_a clears the match-A flag when dack_keep_a is 0 and leaves it unchanged when dack_keep_a is 1. dack_b and dack_keep_b work the same way for match B.
- R8: Status bits 1:0 select the pin action for match A and bits 3:2 select it for match B: 00 hold, 01 drive 0, 10 drive 1, 11 invert. wave_out shows the result on the clock edge that ends the match cycle. Without a match, wave_out holds.
- R9: When both matches fall in the same cycle and the match-B action is not 00, the match-B action is applied. Otherwise the match-A action is applied.
- R10: With status bit 4 set, a match A produces a single-cycle adc_start pulse on the next clock edge. With bit 4 clear, adc_start stays 0.
- R11: irq_cma, irq_cmb and irq_ovf each equal their flag ANDed with ie_a, ie_b and ie_ovf respectively.
- R12: In the variant without converter trigger (HAS_ADC = 0), status bit 4 reads 1, ignores writes, and adc_start never rises.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cnt_en | input | 1 | Count enable strobe |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe (arms flag clearing) |
| bus_addr | input | 2 | Register select |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for the selected register |
| dack_a | input | 1 | Transfer acknowledge for match A |
| dack_b | input | 1 | Transfer acknowledge for match B |
| dack_keep_a | input | 1 | When 1, dack_a leaves the match-A flag set |
| dack_keep_b | input | 1 | When 1, dack_b leaves the match-B flag set |
| ie_a | input | 1 | Interrupt enable, match A |
| ie_b | input | 1 | Interrupt enable, match B |
| ie_ovf | input | 1 | Interrupt enable, overflow |
| irq_cma | output | 1 | Match-A interrupt request |
| irq_cmb | output | 1 | Match-B interrupt request |
| irq_ovf | output | 1 | Overflow interrupt request |
| adc_start | output | 1 | One-cycle converter start pulse |
| wave_out | output | 1 | Waveform output pin |

## Verification
A flag's set event and its software clear can land in the same cycle. The bench arms match A by reading it back as 1, then writes 0 to the status register while cnt_en steps the counter through compare A. A final readback must still show the flag set. Simultaneous A and B matches are also produced by loading both compares with the same value and programming conflicting pin actions, and the pin level after the edge must follow the B action.

// File: rtl/tmr8_pkg.sv
package tmr8_pkg;

    localparam int CNT_W  = 8;
    localparam int DATA_W = 8;
    localparam int N_FLAG = 3;

    typedef enum logic [1:0] {
        ACT_HOLD   = 2'b00,
        ACT_LOW    = 2'b01,
        ACT_HIGH   = 2'b10,
        ACT_TOGGLE = 2'b11
    } pin_act_e;

    typedef enum logic [1:0] {
        REG_COUNT = 2'd0,
        REG_CMP_A = 2'd1,
        REG_CMP_B = 2'd2,
        REG_CTRL  = 2'd3
    } reg_sel_e;

    typedef struct packed {
        logic cmb;
        logic cma;
        logic ovf;
    } evt_t;

    typedef struct packed {
        logic     adc_en;
        pin_act_e act_b;
        pin_act_e act_a;
    } ctrl_t;

    function automatic logic apply_act(logic cur, pin_act_e a);
        case (a)
            ACT_LOW:    return 1'b0;
            ACT_HIGH:   return 1'b1;
            ACT_TOGGLE: return ~cur;
            default:    return cur;
        endcase
    endfunction

    // Match B wins when it asks for a real action.
    function automatic pin_act_e pick_act(evt_t e, ctrl_t c);
        if (e.cmb && (c.act_b != ACT_HOLD))
            return c.act_b;
        else if (e.cma)
            return c.act_a;
        else
            return ACT_HOLD;
    endfunction

endpackage

// File: rtl/tmr8_count.sv
module tmr8_count #(
    parameter int W = 8
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            cnt_en,
    input  logic            load,
    input  logic            ld_a,
    input  logic            ld_b,
    input  logic [W-1:0]    wval,
    output logic [W-1:0]    cnt,
    output logic [W-1:0]    cmp_a,
    output logic [W-1:0]    cmp_b,
    output tmr8_pkg::evt_t  evt
);

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt   <= '0;
            cmp_a <= '1;
            cmp_b <= '1;
        end else begin
            if (load)
                cnt <= wval;
            else if (cnt_en)
                cnt <= cnt + 1'b1;
            if (ld_a)
                cmp_a <= wval;
            if (ld_b)
                cmp_b <= wval;
        end
    end

    always_comb begin
        evt.cma = cnt_en && (cnt == cmp_a);
        evt.cmb = cnt_en && (cnt == cmp_b);
        evt.ovf = cnt_en && (&cnt);
    end

    a_r2_step: assert property (@(posedge clk) disable iff (rst)
        (cnt_en && !load) |=> cnt == W'($past(cnt) + 1'b1));

    a_r2_hold: assert property (@(posedge clk) disable iff (rst)
        (!cnt_en && !load) |=> $stable(cnt));

    a_r2_load: assert property (@(posedge clk) disable iff (rst)
        load |=> cnt == $past(wval));

    a_r3_wrap: assert property (@(posedge clk) disable iff (rst)
        (cnt_en && !load && (&cnt)) |=> cnt == '0);

endmodule

// File: rtl/tmr8_flags.sv
module tmr8_flags (
    input  logic                          clk,
    input  logic                          rst,
    input  tmr8_pkg::evt_t                evt,
    input  logic                          rd_hit,
    input  logic                          wr_hit,
    input  logic [tmr8_pkg::N_FLAG-1:0]   wflag,
    input  logic                          dack_a,
    input  logic                          dack_b,
    input  logic                          keep_a,
    input  logic                          keep_b,
    output logic [tmr8_pkg::N_FLAG-1:0]   flag
);
    import tmr8_pkg::*;

    // bit order {match B, match A, overflow}
    logic [N_FLAG-1:0] arm;
    logic [N_FLAG-1:0] set_v;
    logic [N_FLAG-1:0] clr_sw;
    logic [N_FLAG-1:0] clr_dma;

    always_comb begin
        set_v   = {evt.cmb, evt.cma, evt.ovf};
        clr_sw  = wr_hit ? (arm & ~wflag) : '0;
        clr_dma = {dack_b & ~keep_b, dack_a & ~keep_a, 1'b0};
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            flag <= '0;
            arm  <= '0;
        end else begin
            flag <= (flag & ~(clr_sw | clr_dma)) | set_v;
            if (wr_hit)
                arm <= '0;
            else if (rd_hit)
                arm <= flag;
        end
    end

    for (genvar i = 0; i < N_FLAG; i++) begin : g_chk
        a_r6_set_wins: assert property (@(posedge clk) disable iff (rst)
            set_v[i] |=> flag[i]);

        a_r5_unarmed_keeps: assert property (@(posedge clk) disable iff (rst)
            (flag[i] && !arm[i] && !clr_dma[i]) |=> flag[i]);

        a_r5_write_one_keeps: assert property (@(posedge clk) disable iff (rst)
            (flag[i] && wr_hit && wflag[i] && !clr_dma[i]) |=> flag[i]);

        a_r7_dma_clear: assert property (@(posedge clk) disable iff (rst)
            (clr_dma[i] && !set_v[i]) |=> !flag[i]);
    end

endmodule

// File: rtl/tmr8_wave.sv
module tmr8_wave (
    input  logic              clk,
    input  logic              rst,
    input  tmr8_pkg::evt_t    evt,
    input  tmr8_pkg::ctrl_t   ctrl,
    output logic              wave_out,
    output logic              adc_start
);
    import tmr8_pkg::*;

    pin_act_e sel_act;

    always_comb sel_act = pick_act(evt, ctrl);

    always_ff @(posedge clk) begin
        if (rst) begin
            wave_out  <= 1'b0;
            adc_start <= 1'b0;
        end else begin
            wave_out  <= apply_act(wave_out, sel_act);
            adc_start <= evt.cma & ctrl.adc_en;
        end
    end

    a_r8_hold: assert property (@(posedge clk) disable iff (rst)
        (!evt.cma && !evt.cmb) |=> $stable(wave_out));

    a_r8_low: assert property (@(posedge clk) disable iff (rst)
        (evt.cma && !evt.cmb && ctrl.act_a == ACT_LOW) |=> !wave_out);

    a_r8_toggle: assert property (@(posedge clk) disable iff (rst)
        (evt.cma && !evt.cmb && ctrl.act_a == ACT_TOGGLE) |=> wave_out != $past(wave_out));

    a_r9_b_high: assert property (@(posedge clk) disable iff (rst)
        (evt.cmb && ctrl.act_b == ACT_HIGH) |=> wave_out);

    a_r9_b_low: assert property (@(posedge clk) disable iff (rst)
        (evt.cmb && ctrl.act_b == ACT_LOW) |=> !wave_out);

    a_r10_no_start: assert property (@(posedge clk) disable iff (rst)
        !(evt.cma && ctrl.adc_en) |=> !adc_start);

    a_r10_start: assert property (@(posedge clk) disable iff (rst)
        (evt.cma && ctrl.adc_en) |=> adc_start);

endmodule

// File: rtl/tmr8_channel.sv
module tmr8_channel #(
    parameter bit HAS_ADC = 1'b1,
    parameter int CNT_W   = tmr8_pkg::CNT_W
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       cnt_en,
    input  logic       bus_wr,
    input  logic       bus_rd,
    input  logic [1:0] bus_addr,
    input  logic [7:0] bus_wdata,
    output logic [7:0] bus_rdata,
    input  logic       dack_a,
    input  logic       dack_b,
    input  logic       dack_keep_a,
    input  logic       dack_keep_b,
    input  logic       ie_a,
    input  logic       ie_b,
    input  logic       ie_ovf,
    output logic       irq_cma,
    output logic       irq_cmb,
    output logic       irq_ovf,
    output logic       adc_start,
    output logic       wave_out
);
    import tmr8_pkg::*;

    localparam int DW = DATA_W;

    reg_sel_e          sel;
    logic              wr_cnt, wr_a, wr_b, wr_ctl, rd_ctl;
    logic [CNT_W-1:0]  cnt, cmp_a, cmp_b;
    evt_t              evt;
    ctrl_t             ctrl_q;
    logic [N_FLAG-1:0] flag;
    logic              adc_bit;

    always_comb begin
        sel    = reg_sel_e'(bus_addr);
        wr_cnt = bus_wr && (sel == REG_COUNT);
        wr_a   = bus_wr && (sel == REG_CMP_A);
        wr_b   = bus_wr && (sel == REG_CMP_B);
        wr_ctl = bus_wr && (sel == REG_CTRL);
        rd_ctl = bus_rd && (sel == REG_CTRL);
    end

    tmr8_count #(.W(CNT_W)) u_count (
        .clk    (clk),
        .rst    (rst),
        .cnt_en (cnt_en),
        .load   (wr_cnt),
        .ld_a   (wr_a),
        .ld_b   (wr_b),
        .wval   (bus_wdata[CNT_W-1:0]),
        .cnt    (cnt),
        .cmp_a  (cmp_a),
        .cmp_b  (cmp_b),
        .evt    (evt)
    );

    tmr8_flags u_flags (
        .clk    (clk),
        .rst    (rst),
        .evt    (evt),
        .rd_hit (rd_ctl),
        .wr_hit (wr_ctl),
        .wflag  (bus_wdata[7:5]),
        .dack_a (dack_a),
        .dack_b (dack_b),
        .keep_a (dack_keep_a),
        .keep_b (dack_keep_b),
        .flag   (flag)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_q <= '0;
        end else if (wr_ctl) begin
            ctrl_q.act_a  <= pin_act_e'(bus_wdata[1:0]);
            ctrl_q.act_b  <= pin_act_e'(bus_wdata[3:2]);
            ctrl_q.adc_en <= HAS_ADC & bus_wdata[4];
        end
    end

    tmr8_wave u_wave (
        .clk       (clk),
        .rst       (rst),
        .evt       (evt),
        .ctrl      (ctrl_q),
        .wave_out  (wave_out),
        .adc_start (adc_start)
    );

    generate
        if (HAS_ADC) begin : g_adc
            assign adc_bit = ctrl_q.adc_en;
        end else begin : g_no_adc
            assign adc_bit = 1'b1;

            a_r12_no_start: assert property (@(posedge clk) disable iff (rst)
                !adc_start);

            a_r12_bit_fixed: assert property (@(posedge clk) disable iff (rst)
                !ctrl_q.adc_en);
        end
    endgenerate

    always_comb begin
        case (sel)
            REG_COUNT: bus_rdata = DW'(cnt);
            REG_CMP_A: bus_rdata = DW'(cmp_a);
            REG_CMP_B: bus_rdata = DW'(cmp_b);
            default:   bus_rdata = {flag, adc_bit, ctrl_q.act_b, ctrl_q.act_a};
        endcase
    end

    // flag vector order is {match B, match A, overflow}
    assign irq_cmb = flag[2] & ie_b;
    assign irq_cma = flag[1] & ie_a;
    assign irq_ovf = flag[0] & ie_ovf;

    a_r11_irq_needs_enable: assert property (@(posedge clk) disable iff (rst)
        (irq_cma -> ie_a) && (irq_cmb -> ie_b) && (irq_ovf -> ie_ovf));

endmodule

// File: tb/tmr8_channel_bench.sv
module tmr8_channel_bench;

    logic       clk = 1'b0;
    logic       rst;
    logic       cnt_en, bus_wr, bus_rd;
    logic [1:0] bus_addr;
    logic [7:0] bus_wdata, bus_rdata, rdata_n;
    logic       dack_a, dack_b, dack_keep_a, dack_keep_b;
    logic       ie_a, ie_b, ie_ovf;
    logic       irq_cma, irq_cmb, irq_ovf, adc_start, wave_out;
    logic       irq_cma_n, irq_cmb_n, irq_ovf_n, adc_n, wave_n;

    int n_chk  = 0;
    int n_fail = 0;
    logic [7:0] last_n;

    always #5 clk = ~clk;

    tmr8_channel #(.HAS_ADC(1'b1)) u_tmr8_channel (
        .clk(clk), .rst(rst), .cnt_en(cnt_en), .bus_wr(bus_wr), .bus_rd(bus_rd),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .dack_a(dack_a), .dack_b(dack_b), .dack_keep_a(dack_keep_a), .dack_keep_b(dack_keep_b),
        .ie_a(ie_a), .ie_b(ie_b), .ie_ovf(ie_ovf),
        .irq_cma(irq_cma), .irq_cmb(irq_cmb), .irq_ovf(irq_ovf),
        .adc_start(adc_start), .wave_out(wave_out)
    );

    tmr8_channel #(.HAS_ADC(1'b0)) u_tmr8_channel_noadc (
        .clk(clk), .rst(rst), .cnt_en(cnt_en), .bus_wr(bus_wr), .bus_rd(bus_rd),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(rdata_n),
        .dack_a(dack_a), .dack_b(dack_b), .dack_keep_a(dack_keep_a), .dack_keep_b(dack_keep_b),
        .ie_a(ie_a), .ie_b(ie_b), .ie_ovf(ie_ovf),
        .irq_cma(irq_cma_n), .irq_cmb(irq_cmb_n), .irq_ovf(irq_ovf_n),
        .adc_start(adc_n), .wave_out(wave_n)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    task automatic finish_up();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    endtask

    task automatic cyc();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic wr(input logic [1:0] a, input logic [7:0] d);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        cyc();
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [1:0] a, output logic [7:0] d);
        bus_rd = 1'b1; bus_addr = a;
        #1;
        d = bus_rdata;
        last_n = rdata_n;
        cyc();
        bus_rd = 1'b0;
    endtask

    task automatic tick(input int n);
        cnt_en = 1'b1;
        repeat (n) cyc();
        cnt_en = 1'b0;
    endtask

    task automatic expect_reg(input logic [1:0] a, input logic [7:0] exp, input string req);
        logic [7:0] d;
        rd(a, d);
        chk(d == exp, req, d, exp);
    endtask

    // reference pin action, from the encoding in R8
    function automatic logic f_pin(input logic cur, input logic [1:0] a);
        case (a)
            2'b01:   return 1'b0;
            2'b10:   return 1'b1;
            2'b11:   return ~cur;
            default: return cur;
        endcase
    endfunction

    initial begin
        #2_000_000;
        n_chk++;
        n_fail++;
        $display("FAIL watchdog expired actual=0x0 expected=0x1");
        finish_up();
    end

    initial begin
        logic [7:0] d;
        logic [7:0] ca, cb, ctl, m_cnt;
        logic [2:0] m_flag;
        logic       m_wave, m_adc, en, ea, eb, eo;
        logic [1:0] act;

        void'($urandom(32'd20240611));
        rst = 1'b1; cnt_en = 0; bus_wr = 0; bus_rd = 0; bus_addr = 0; bus_wdata = 0;
        dack_a = 0; dack_b = 0; dack_keep_a = 0; dack_keep_b = 0;
        ie_a = 0; ie_b = 0; ie_ovf = 0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // R1 reset state
        expect_reg(2'd3, 8'h00, "R1 status");
        chk(last_n == 8'h10, "R1 R12 variant status", last_n, 8'h10);
        expect_reg(2'd0, 8'h00, "R1 counter");
        expect_reg(2'd1, 8'hFF, "R1 compare A");
        expect_reg(2'd2, 8'hFF, "R1 compare B");
        chk({wave_out, adc_start, irq_cma, irq_cmb, irq_ovf} == 5'b0, "R1 outputs",
            {wave_out, adc_start, irq_cma, irq_cmb, irq_ovf}, 0);

        // R2 count, hold, load
        wr(2'd0, 8'h10);
        tick(5);
        expect_reg(2'd0, 8'h15, "R2 count");
        repeat (3) cyc();
        expect_reg(2'd0, 8'h15, "R2 hold");

        // R3 wrap
        wr(2'd1, 8'h80);
        wr(2'd2, 8'h81);
        wr(2'd0, 8'hFE);
        tick(1);
        expect_reg(2'd3, 8'h00, "R3 no flag before wrap");
        tick(1);
        expect_reg(2'd0, 8'h00, "R3 counter wrapped");
        expect_reg(2'd3, 8'h20, "R3 overflow flag");

        // R5 clear handshake
        wr(2'd3, 8'hE0);
        wr(2'd3, 8'h00);
        expect_reg(2'd3, 8'h20, "R5 write without read");
        wr(2'd3, 8'h20);
        wr(2'd3, 8'h00);
        expect_reg(2'd3, 8'h20, "R5 arm dropped by write");
        wr(2'd3, 8'h00);
        expect_reg(2'd3, 8'h00, "R5 armed clear");

        // R4 matches
        wr(2'd1, 8'h05);
        wr(2'd0, 8'h05);
        tick(1);
        expect_reg(2'd3, 8'h40, "R4 match A");
        wr(2'd2, 8'h09);
        wr(2'd0, 8'h09);
        tick(1);
        expect_reg(2'd3, 8'hC0, "R4 match B");

        // R11 interrupt gating
        ie_a = 1'b1; #1;
        chk({irq_cmb, irq_cma, irq_ovf} == 3'b010, "R11 irq A only", {irq_cmb, irq_cma, irq_ovf}, 3'b010);
        ie_b = 1'b1; #1;
        chk({irq_cmb, irq_cma, irq_ovf} == 3'b110, "R11 irq A and B", {irq_cmb, irq_cma, irq_ovf}, 3'b110);
        ie_ovf = 1'b1; #1;
        chk(irq_ovf == 1'b0, "R11 irq ovf with flag clear", irq_ovf, 0);
        ie_a = 0; ie_b = 0; ie_ovf = 0; #1;
        chk({irq_cmb, irq_cma} == 2'b00, "R11 irq disabled", {irq_cmb, irq_cma}, 0);
        @(negedge clk);

        // R7 acknowledge clearing
        dack_a = 1'b1; dack_keep_a = 1'b1;
        cyc();
        dack_a = 1'b0; dack_keep_a = 1'b0;
        expect_reg(2'd3, 8'hC0, "R7 keep qualifier");
        dack_a = 1'b1;
        cyc();
        dack_a = 1'b0;
        expect_reg(2'd3, 8'h80, "R7 clear A");
        dack_b = 1'b1;
        cyc();
        dack_b = 1'b0;
        expect_reg(2'd3, 8'h00, "R7 clear B");

        // R6 set beats clear
        wr(2'd0, 8'h05);
        tick(1);
        wr(2'd0, 8'h05);
        expect_reg(2'd3, 8'h40, "R6 flag set before");
        cnt_en = 1'b1;
        wr(2'd3, 8'h00);
        cnt_en = 1'b0;
        expect_reg(2'd3, 8'h40, "R6 set wins");
        wr(2'd3, 8'h00);
        expect_reg(2'd3, 8'h00, "R6 clear after");

        // R8 pin actions (compare A = 0x05, compare B = 0x09)
        wr(2'd3, 8'h02); wr(2'd0, 8'h05); tick(1);
        chk(wave_out == 1'b1, "R8 drive high", wave_out, 1);
        wr(2'd3, 8'h01); wr(2'd0, 8'h05); tick(1);
        chk(wave_out == 1'b0, "R8 drive low", wave_out, 0);
        wr(2'd3, 8'h03); wr(2'd0, 8'h05); tick(1);
        chk(wave_out == 1'b1, "R8 toggle up", wave_out, 1);
        wr(2'd0, 8'h05); tick(1);
        chk(wave_out == 1'b0, "R8 toggle down", wave_out, 0);
        wr(2'd0, 8'h05); tick(1);
        wr(2'd3, 8'h00); wr(2'd0, 8'h05); tick(1);
        chk(wave_out == 1'b1, "R8 hold action", wave_out, 1);
        wr(2'd3, 8'h01); tick(3);
        chk(wave_out == 1'b1, "R8 no match holds", wave_out, 1);

        // R9 simultaneous matches
        wr(2'd2, 8'h05);
        wr(2'd3, 8'h06); wr(2'd0, 8'h05); tick(1);
        chk(wave_out == 1'b0, "R9 B low over A high", wave_out, 0);
        wr(2'd3, 8'h09); wr(2'd0, 8'h05); tick(1);
        chk(wave_out == 1'b1, "R9 B high over A low", wave_out, 1);
        wr(2'd3, 8'h01); wr(2'd0, 8'h05); tick(1);
        chk(wave_out == 1'b0, "R9 B hold lets A act", wave_out, 0);

        // R10 converter start, R12 variant
        wr(2'd2, 8'h80);
        wr(2'd3, 8'h10);
        rd(2'd3, d);
        chk(d[4] == 1'b1, "R10 enable bit", d[4], 1);
        chk(last_n[4] == 1'b1, "R12 bit reads 1", last_n[4], 1);
        wr(2'd0, 8'h05);
        cnt_en = 1'b1;
        cyc();
        chk(adc_start == 1'b1, "R10 pulse", adc_start, 1);
        chk(adc_n == 1'b0, "R12 no pulse", adc_n, 0);
        cyc();
        cnt_en = 1'b0;
        chk(adc_start == 1'b0, "R10 single cycle", adc_start, 0);
        wr(2'd3, 8'h00);
        rd(2'd3, d);
        chk(last_n[4] == 1'b1, "R12 ignores write", last_n[4], 1);
        wr(2'd0, 8'h05);
        tick(1);
        chk(adc_start == 1'b0, "R10 disabled", adc_start, 0);

        // random rounds against the reference model (R2 R3 R4 R8 R9 R10)
        for (int r = 0; r < 20; r++) begin
            ca  = 8'($urandom);
            cb  = (r % 4 == 0) ? ca : 8'($urandom);
            ctl = 8'($urandom) & 8'h1F;
            wr(2'd1, ca);
            wr(2'd2, cb);
            rd(2'd3, d);
            wr(2'd3, ctl);
            m_cnt = 8'($urandom);
            wr(2'd0, m_cnt);
            m_flag = 3'b000;
            m_wave = wave_out;
            for (int k = 0; k < 200; k++) begin
                en = ($urandom % 4) != 0;
                ea = en && (m_cnt == ca);
                eb = en && (m_cnt == cb);
                eo = en && (m_cnt == 8'hFF);
                if (eb && ctl[3:2] != 2'b00) act = ctl[3:2];
                else if (ea)                 act = ctl[1:0];
                else                         act = 2'b00;
                m_wave = f_pin(m_wave, act);
                m_adc  = ea && ctl[4];
                m_flag = m_flag | {eb, ea, eo};
                m_cnt  = m_cnt + 8'(en);
                cnt_en = en;
                cyc();
                chk(wave_out == m_wave, "R8 R9 random pin", wave_out, m_wave);
                chk(adc_start == m_adc, "R10 random pulse", adc_start, m_adc);
            end
            cnt_en = 1'b0;
            expect_reg(2'd0, m_cnt, "R2 random count");
            expect_reg(2'd3, {m_flag, ctl[4:0]}, "R3 R4 random flags");
        end

        finish_up();
    end

endmodule